// File: doc/BRIEF.md
# CAN Fault-Confinement State and Error Interrupt Flags

This block follows the fault-confinement state of a CAN node and keeps three sticky interrupt flags. The flags cover overload detection, bus-off transitions and error-passive entry. It takes the current transmit and receive error counter values from the protocol engine. It also takes a strobe for each sampled bit, together with that bit's level, and an overload-detect pulse. Its control inputs are listen-only mode, a test input that forces error-passive, and a halt request. From these it keeps a state register (error-active, error-passive, bus-off, halt) and runs the bus-off recovery count on its own.

Software reads the flags and clears any of them by writing a mask in which a 1 marks each flag to drop. A flag only tells software that an event happened. The state output says where the node is now, so a cleared flag can sit beside a state that still holds. A combinational overload-frame request goes to the frame generator. It is withheld in listen-only mode and whenever the node may not transmit.

Top module: `can_errflag_unit`

## Requirements
- R1: On synchronous reset the state is error-active (nodeState = 0) and all three flags are 0. The state codes are 0 error-active, 1 error-passive, 2 bus-off and 3 halt.
- R2: A cycle with overloadDet high sets flag bit 2 at the next clock edge, in every state and also while listenOnly is high.
- R3: overloadTxReq equals overloadDet when the node is error-active or error-passive and listenOnly is low. It is 0 in every other case.
- R4: A cycle with flagWrEn high clears each flag whose bit in flagWrData is 1. Bits written 0 leave their flag unchanged, and no flag ever clears without such a write.
- R5: When a flag's set event and a clear of that flag fall in the same cycle, the flag is 1 afterwards.
- R6: From error-active or error-passive, a transmit counter of BUSOFF_LIMIT (default 256) or more moves the node to bus-off and sets flag bit 1. This check wins over the halt request and over the error-passive test.
- R7: In bus-off, each strobed recessive bit advances a run counter and each strobed dominant bit resets it. Cycles without a strobe change nothing. Every RUN_LEN (11) recessive bits in a row form one sequence. The strobed bit that completes sequence number RECOV_SEQS (default 128) returns the node to error-active and sets flag bit 1.
- R8: haltReq moves bus-off to halt and sets flag bit 1. It moves error-active or error-passive to halt without setting any flag. Halt returns to error-active once haltReq is low.
- R9: From error-active, a transmit or receive counter of PASSIVE_LIMIT (default 128) or more, or forcePassive high, moves the node to error-passive. This sets flag bit 0 only on entry and not in later cycles while the condition holds. The node returns to error-active when the condition ends.
- R10: Clearing flag bit 1 during bus-off, or flag bit 0 during error-passive, leaves nodeState unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tecIn | input | CNT_W | Transmit error counter value |
| recIn | input | CNT_W | Receive error counter value |
| bitStrobe | input | 1 | One-cycle strobe per sampled bus bit |
| bitRecessive | input | 1 | Level of the strobed bit, 1 = recessive |
| overloadDet | input | 1 | Overload condition detected this cycle |
| listenOnly | input | 1 | Listen-only mode, transmission blocked |
| forcePassive | input | 1 | Test input forcing error-passive |
| haltReq | input | 1 | Halt request |
| flagWrEn | input | 1 | Flag clear write strobe |
| flagWrData | input | 3 | Clear mask: bit 0 error-passive, bit 1 bus-off, bit 2 overload |
| nodeState | output | 2 | Current state, encoded as in R1 |
| irqFlags | output | 3 | Sticky flags, same bit order as flagWrData |
| overloadTxReq | output | 1 | Request to send an overload frame |

## Verification
The bench sets RECOV_SEQS to 3 and keeps RUN_LEN at 11, so a complete bus-off recovery needs only 33 strobed recessive bits. That makes it practical to check the exact bit that ends recovery, a dominant bit that restarts a run, and idle cycles with no strobe. The counter width and both thresholds stay at their defaults. This puts the boundary values 127, 128, 255 and 256 under direct test, including a flag clear that lands in the same cycle as a new entry into error-passive.

// File: rtl/can_errflag_pkg.sv
package can_errflag_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_PASSIVE = 2'd1,
    ST_BUSOFF  = 2'd2,
    ST_HALT    = 2'd3
  } node_state_e;

  localparam int FLAG_W    = 3;
  localparam int FLAG_PASS = 0;
  localparam int FLAG_BOFF = 1;
  localparam int FLAG_OVL  = 2;

  // control -> datapath strobes
  typedef struct packed {
    logic setBusOff;
    logic setPassive;
    logic recovRun;
  } ctrl_strobe_t;

  // datapath -> control status
  typedef struct packed {
    logic tecBusOff;
    logic errPassive;
    logic recovDone;
  } dp_status_t;

endpackage

// File: rtl/can_errflag_dp.sv
module can_errflag_dp
  import can_errflag_pkg::*;
#(
  parameter int CNT_W         = 9,
  parameter int PASSIVE_LIMIT = 128,
  parameter int BUSOFF_LIMIT  = 256,
  parameter int RUN_LEN       = 11,
  parameter int RECOV_SEQS    = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  tecIn,
  input  logic [CNT_W-1:0]  recIn,
  input  logic              forcePassive,
  input  logic              bitStrobe,
  input  logic              bitRecessive,
  input  logic              overloadDet,
  input  logic              flagWrEn,
  input  logic [FLAG_W-1:0] flagWrData,
  input  ctrl_strobe_t      strobes,
  output dp_status_t        status,
  output logic [FLAG_W-1:0] irqFlags
);

  localparam int RUN_W = $clog2(RUN_LEN);
  localparam int SEQ_W = $clog2(RECOV_SEQS + 1);
  localparam logic [CNT_W-1:0] PASS_TH = CNT_W'(PASSIVE_LIMIT);
  localparam logic [CNT_W-1:0] BOFF_TH = CNT_W'(BUSOFF_LIMIT);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
  localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(RECOV_SEQS - 1);

  // threshold comparators
  logic tecPassive, recPassive;
  always_comb begin
    tecPassive        = (tecIn >= PASS_TH);
    recPassive        = (recIn >= PASS_TH);
    status.tecBusOff  = (tecIn >= BOFF_TH);
    status.errPassive = tecPassive | recPassive | forcePassive;
  end

  // bus-off recovery: recessive run counter and sequence counter
  logic [RUN_W-1:0] runCnt;
  logic [SEQ_W-1:0] seqCnt;
  logic runEnd;

  always_comb begin
    runEnd           = bitStrobe & bitRecessive & (runCnt == RUN_LAST);
    status.recovDone = strobes.recovRun & runEnd & (seqCnt == SEQ_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst || !strobes.recovRun) begin
      runCnt <= '0;
      seqCnt <= '0;
    end else if (bitStrobe) begin
      if (!bitRecessive) begin
        runCnt <= '0;
      end else if (runEnd) begin
        runCnt <= '0;
        seqCnt <= seqCnt + 1'b1;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  // sticky flag register, set wins over clear
  logic [FLAG_W-1:0] setMask, clrMask;
  always_comb begin
    setMask            = '0;
    setMask[FLAG_OVL]  = overloadDet;
    setMask[FLAG_BOFF] = strobes.setBusOff;
    setMask[FLAG_PASS] = strobes.setPassive;
    clrMask            = flagWrEn ? flagWrData : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) irqFlags <= '0;
    else     irqFlags <= (irqFlags & ~clrMask) | setMask;
  end

endmodule

// File: rtl/can_errflag_ctrl.sv
module can_errflag_ctrl
  import can_errflag_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         haltReq,
  input  logic         overloadDet,
  input  logic         listenOnly,
  input  dp_status_t   status,
  output ctrl_strobe_t strobes,
  output logic [1:0]   nodeState,
  output logic         overloadTxReq
);

  node_state_e stateQ, stateD;

  always_comb begin
    stateD             = stateQ;
    strobes.setBusOff  = 1'b0;
    strobes.setPassive = 1'b0;
    strobes.recovRun   = (stateQ == ST_BUSOFF);
    unique case (stateQ)
      ST_ACTIVE, ST_PASSIVE: begin
        if (status.tecBusOff) begin
          stateD            = ST_BUSOFF;
          strobes.setBusOff = 1'b1;
        end else if (haltReq) begin
          stateD = ST_HALT;
        end else if (status.errPassive) begin
          stateD             = ST_PASSIVE;
          strobes.setPassive = (stateQ != ST_PASSIVE);
        end else begin
          stateD = ST_ACTIVE;
        end
      end
      ST_BUSOFF: begin
        if (haltReq) begin
          stateD            = ST_HALT;
          strobes.setBusOff = 1'b1;
        end else if (status.recovDone) begin
          stateD            = ST_ACTIVE;
          strobes.setBusOff = 1'b1;
        end
      end
      ST_HALT: begin
        if (!haltReq) stateD = ST_ACTIVE;
      end
      default: stateD = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_ACTIVE;
    else     stateQ <= stateD;
  end

  always_comb begin
    nodeState     = stateQ;
    overloadTxReq = overloadDet & ~listenOnly &
                    ((stateQ == ST_ACTIVE) || (stateQ == ST_PASSIVE));
  end

endmodule

// File: rtl/can_errflag_unit.sv
module can_errflag_unit
  import can_errflag_pkg::*;
#(
  parameter int CNT_W         = 9,
  parameter int PASSIVE_LIMIT = 128,
  parameter int BUSOFF_LIMIT  = 256,
  parameter int RUN_LEN       = 11,
  parameter int RECOV_SEQS    = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] tecIn,
  input  logic [CNT_W-1:0] recIn,
  input  logic             bitStrobe,
  input  logic             bitRecessive,
  input  logic             overloadDet,
  input  logic             listenOnly,
  input  logic             forcePassive,
  input  logic             haltReq,
  input  logic             flagWrEn,
  input  logic [2:0]       flagWrData,
  output logic [1:0]       nodeState,
  output logic [2:0]       irqFlags,
  output logic             overloadTxReq
);

  ctrl_strobe_t strobes;
  dp_status_t   status;

  can_errflag_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .haltReq       (haltReq),
    .overloadDet   (overloadDet),
    .listenOnly    (listenOnly),
    .status        (status),
    .strobes       (strobes),
    .nodeState     (nodeState),
    .overloadTxReq (overloadTxReq)
  );

  can_errflag_dp #(
    .CNT_W         (CNT_W),
    .PASSIVE_LIMIT (PASSIVE_LIMIT),
    .BUSOFF_LIMIT  (BUSOFF_LIMIT),
    .RUN_LEN       (RUN_LEN),
    .RECOV_SEQS    (RECOV_SEQS)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .tecIn        (tecIn),
    .recIn        (recIn),
    .forcePassive (forcePassive),
    .bitStrobe    (bitStrobe),
    .bitRecessive (bitRecessive),
    .overloadDet  (overloadDet),
    .flagWrEn     (flagWrEn),
    .flagWrData   (flagWrData),
    .strobes      (strobes),
    .status       (status),
    .irqFlags     (irqFlags)
  );

endmodule

// File: rtl/can_errflag_chk.sv
module can_errflag_chk #(
  parameter int CNT_W        = 9,
  parameter int BUSOFF_LIMIT = 256
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] tecIn,
  input logic             overloadDet,
  input logic             listenOnly,
  input logic             haltReq,
  input logic             flagWrEn,
  input logic [2:0]       flagWrData,
  input logic [1:0]       nodeState,
  input logic [2:0]       irqFlags,
  input logic             overloadTxReq
);

  localparam logic [CNT_W-1:0] BOFF_TH = CNT_W'(BUSOFF_LIMIT);

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (nodeState == 2'd0 && irqFlags == 3'b000)); // R1

  AST_OVL_SETS: assert property (@(posedge clk) disable iff (rst)
    overloadDet |=> irqFlags[2]); // R2

  AST_TX_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
    (listenOnly || nodeState[1]) |-> !overloadTxReq); // R3

  for (genvar i = 0; i < 3; i++) begin : g_hold
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
      (irqFlags[i] && !(flagWrEn && flagWrData[i])) |=> irqFlags[i]); // R4
  end

  AST_BUSOFF_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (!nodeState[1] && tecIn >= BOFF_TH) |=> (nodeState == 2'd2 && irqFlags[1])); // R6

  AST_BUSOFF_EXIT: assert property (@(posedge clk) disable iff (rst)
    ($past(nodeState) == 2'd2 && nodeState != 2'd2 && !$past(rst)) |-> irqFlags[1]); // R7

  AST_HALT_PATH: assert property (@(posedge clk) disable iff (rst)
    (nodeState == 2'd3 && !haltReq) |=> (nodeState == 2'd0)); // R8

  AST_PASSIVE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    ($past(nodeState) != 2'd1 && nodeState == 2'd1 && !$past(rst)) |-> irqFlags[0]); // R9

endmodule

bind can_errflag_unit can_errflag_chk #(
  .CNT_W        (CNT_W),
  .BUSOFF_LIMIT (BUSOFF_LIMIT)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .tecIn         (tecIn),
  .overloadDet   (overloadDet),
  .listenOnly    (listenOnly),
  .haltReq       (haltReq),
  .flagWrEn      (flagWrEn),
  .flagWrData    (flagWrData),
  .nodeState     (nodeState),
  .irqFlags      (irqFlags),
  .overloadTxReq (overloadTxReq)
);

// File: tb/can_errflag_unit_tb.sv
module can_errflag_unit_tb;

  localparam int CNT_W      = 9;
  localparam int RUN_LEN    = 11;
  localparam int RECOV_SEQS = 3;
  localparam int NVEC       = 24;

  logic             clk = 1'b0;
  logic             rst;
  logic [CNT_W-1:0] tecIn, recIn;
  logic             bitStrobe, bitRecessive, overloadDet, listenOnly;
  logic             forcePassive, haltReq, flagWrEn;
  logic [2:0]       flagWrData;
  logic [1:0]       nodeState;
  logic [2:0]       irqFlags;
  logic             overloadTxReq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  can_errflag_unit #(
    .CNT_W      (CNT_W),
    .RUN_LEN    (RUN_LEN),
    .RECOV_SEQS (RECOV_SEQS)
  ) u_dut (
    .clk           (clk),
    .rst           (rst),
    .tecIn         (tecIn),
    .recIn         (recIn),
    .bitStrobe     (bitStrobe),
    .bitRecessive  (bitRecessive),
    .overloadDet   (overloadDet),
    .listenOnly    (listenOnly),
    .forcePassive  (forcePassive),
    .haltReq       (haltReq),
    .flagWrEn      (flagWrEn),
    .flagWrData    (flagWrData),
    .nodeState     (nodeState),
    .irqFlags      (irqFlags),
    .overloadTxReq (overloadTxReq)
  );

  // {tec[9], rec[9], ovl, lo, fp, halt, wr, wd[3], expState[2], expFlags[3], expTx}
  localparam logic [31:0] VEC [0:NVEC-1] = '{
    {9'd0,   9'd0,   1'b0,1'b0,1'b0,1'b0, 1'b0,3'b000, 2'd0,3'b000,1'b0}, // 0  idle
    {9'd0,   9'd0,   1'b1,1'b0,1'b0,1'b0, 1'b0,3'b000, 2'd0,3'b100,1'b1}, // 1  R2 R3
    {9'd0,   9'd0,   1'b1,1'b1,1'b0,1'b0, 1'b0,3'b000, 2'd0,3'b100,1'b0}, // 2  R2 R3 listen-only
    {9'd0,   9'd0,   1'b0,1'b0,1'b0,1'b0, 1'b1,3'b011, 2'd0,3'b100,1'b0}, // 3  R4 zero bit kept
    {9'd0,   9'd0,   1'b0,1'b0,1'b0,1'b0, 1'b1,3'b100, 2'd0,3'b000,1'b0}, // 4  R4
    {9'd0,   9'd128, 1'b0,1'b0,1'b0,1'b0, 1'b0,3'b000, 2'd1,3'b001,1'b0}, // 5  R9 rec boundary
    {9'd0,   9'd200, 1'b0,1'b0,1'b0,1'b0, 1'b0,3'b000, 2'd1,3'b001,1'b0}, // 6  R9
    {9'd0,   9'd200, 1'b0,1'b0,1'b0,1'b0, 1'b1,3'b001, 2'd1,3'b000,1'b0}, // 7  R10
    {9'd0,   9'd130, 1'b0,1'b0,1'b0,1'b0, 1'b0,3'b000, 2'd1,3'b000,1'b0}, // 8  R9 no re-set
    {9'd0,   9'd0,   1'b1,1'b0,1'b0,1'b0, 1'b0,3'b000, 2'd0,3'b100,1'b1}, // 9  R3 passive tx
    {9'd0,   9'd0,   1'b0,1'b0,1'b1,1'b0, 1'b0,3'b000, 2'd1,3'b101,1'b0}, // 10 R9 forced
    {9'd0,   9'd0,   1'b0,1'b0,1'b0,1'b0, 1'b1,3'b101, 2'd0,3'b000,1'b0}, // 11 R9 R4
    {9'd128, 9'd0,   1'b0,1'b0,1'b0,1'b0, 1'b1,3'b001, 2'd1,3'b001,1'b0}, // 12 R5
    {9'd127, 9'd0,   1'b0,1'b0,1'b0,1'b0, 1'b1,3'b001, 2'd0,3'b000,1'b0}, // 13 R9 below
    {9'd256, 9'd0,   1'b0,1'b0,1'b0,1'b0, 1'b0,3'b000, 2'd2,3'b010,1'b0}, // 14 R6
    {9'd300, 9'd0,   1'b1,1'b0,1'b0,1'b0, 1'b0,3'b000, 2'd2,3'b110,1'b0}, // 15 R2 R3 bus-off
    {9'd300, 9'd0,   1'b0,1'b0,1'b0,1'b0, 1'b1,3'b110, 2'd2,3'b000,1'b0}, // 16 R10
    {9'd300, 9'd0,   1'b0,1'b0,1'b0,1'b1, 1'b0,3'b000, 2'd3,3'b010,1'b0}, // 17 R8
    {9'd0,   9'd0,   1'b1,1'b0,1'b0,1'b1, 1'b0,3'b000, 2'd3,3'b110,1'b0}, // 18 R8 R3 halt
    {9'd0,   9'd0,   1'b0,1'b0,1'b0,1'b0, 1'b0,3'b000, 2'd0,3'b110,1'b0}, // 19 R8 release
    {9'd0,   9'd0,   1'b0,1'b0,1'b0,1'b1, 1'b0,3'b000, 2'd3,3'b110,1'b0}, // 20 R8 no flag
    {9'd0,   9'd0,   1'b0,1'b0,1'b0,1'b0, 1'b1,3'b110, 2'd0,3'b000,1'b0}, // 21 R4
    {9'd255, 9'd0,   1'b0,1'b0,1'b0,1'b0, 1'b0,3'b000, 2'd1,3'b001,1'b0}, // 22 R6 below
    {9'd0,   9'd127, 1'b0,1'b0,1'b0,1'b0, 1'b0,3'b000, 2'd0,3'b001,1'b0}  // 23 R9 below
  };

  function automatic string vecTag(int i);
    case (i)
      0:  return "R1";
      1, 2: return "R2";
      3, 4, 11, 21: return "R4";
      12: return "R5";
      14, 22: return "R6";
      7, 16: return "R10";
      17, 18, 19, 20: return "R8";
      9, 15: return "R3";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic idleInputs();
    tecIn = '0; recIn = '0; bitStrobe = 1'b0; bitRecessive = 1'b1;
    overloadDet = 1'b0; listenOnly = 1'b0; forcePassive = 1'b0;
    haltReq = 1'b0; flagWrEn = 1'b0; flagWrData = 3'b000;
  endtask

  task automatic sendBit(logic rec, logic strobe);
    @(negedge clk);
    bitStrobe = strobe; bitRecessive = rec;
    @(negedge clk);
    bitStrobe = 1'b0; bitRecessive = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idleInputs();
    rst = 1'b1;
    forcePassive = 1'b1;
    overloadDet = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", nodeState, 0, "state under reset");
    check("R1", irqFlags, 0, "flags under reset");
    idleInputs();
    rst = 1'b0;

    // table walk: apply at negedge, check tx now, state/flags next negedge
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      tecIn        = VEC[i][31:23];
      recIn        = VEC[i][22:14];
      overloadDet  = VEC[i][13];
      listenOnly   = VEC[i][12];
      forcePassive = VEC[i][11];
      haltReq      = VEC[i][10];
      flagWrEn     = VEC[i][9];
      flagWrData   = VEC[i][8:6];
      #1;
      check(vecTag(i), overloadTxReq, VEC[i][0], $sformatf("vec%0d overloadTxReq", i));
      @(negedge clk);
      check(vecTag(i), nodeState, VEC[i][5:4], $sformatf("vec%0d state", i));
      check(vecTag(i), irqFlags, VEC[i][3:1], $sformatf("vec%0d flags", i));
      idleInputs();
      tecIn = VEC[i][31:23];
      recIn = VEC[i][22:14];
      haltReq = VEC[i][10];
    end

    // R7: bus-off recovery with dominant restart and idle cycles
    @(negedge clk);
    idleInputs();
    flagWrEn = 1'b1; flagWrData = 3'b111; tecIn = 9'd256;
    @(negedge clk);
    idleInputs();
    check("R7", nodeState, 2, "enter bus-off");
    flagWrEn = 1'b1; flagWrData = 3'b010;
    @(negedge clk);
    idleInputs();
    for (int b = 0; b < RUN_LEN - 1; b++) sendBit(1'b1, 1'b1);
    sendBit(1'b0, 1'b1);
    for (int b = 0; b < 5; b++) sendBit(1'b1, 1'b0);
    for (int b = 0; b < RUN_LEN * RECOV_SEQS - 1; b++) sendBit(1'b1, 1'b1);
    check("R7", nodeState, 2, "still bus-off one bit before end");
    check("R7", irqFlags, 0, "no flag before recovery end");
    sendBit(1'b1, 1'b1);
    check("R7", nodeState, 0, "recovered to active");
    check("R7", irqFlags, 2, "bus-off flag on recovery");

    // R1: reset mid-operation
    @(negedge clk);
    rst = 1'b1; overloadDet = 1'b1;
    @(negedge clk);
    idleInputs();
    rst = 1'b0;
    check("R1", irqFlags, 0, "flags after late reset");
    check("R1", nodeState, 0, "state after late reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule